// File: doc/BRIEF.md
# RGB Threshold Alpha Keyer and 16-bit Packer

This block post-processes the RGB32 pixels of a decoded macroblock, taking one pixel per cycle on a valid/ready stream and returning one pixel per cycle on a second valid/ready stream. Each pixel is compared against two programmable darkness levels. A pixel darker than the low level on all three colour channels is erased completely. A pixel darker than the high level is kept, but its alpha is forced to the half-transparent code 0x40. An optional sign mode then flips the top bit of each colour channel.

The result is emitted either as a full RGB32 word or packed to RGB16 with a single alpha bit. The format and sign mode are sampled with each pixel. A threshold command loads both levels in one write. A last flag marks the final pixel of every macroblock of `MB_DIM` x `MB_DIM` pixels; the default is 256 pixels.

Pixel layout: R in bits [7:0], G in [15:8], B in [23:16], alpha in [31:24].

Top module: `rgb_key_packer`

## Requirements
- R1: A cycle with cmd_we_i high loads the low level from cmd_i[7:0] and the high level from cmd_i[23:16]. All other command bits are ignored. The new levels apply to pixels accepted in later cycles. Both levels are zero after reset.
- R2: When R, G and B are all strictly below the low level, the whole 32-bit pixel, alpha included, becomes zero. This rule has priority over R3.
- R3: Otherwise, when R, G and B are all strictly below the high level, alpha becomes 0x40 and the colour channels are unchanged. This rule still applies when the low level is zero.
- R4: When both levels are zero, a pixel passes through unchanged apart from the sign mode.
- R5: With sign_i high, the thresholded pixel is XORed with 0x00808080. The sign is applied after R2 and R3, so an erased pixel becomes 0x00808080.
- R6: With fmt16_i high, the output is packed as follows: bits [4:0]=R[7:3], [9:5]=G[7:3], [14:10]=B[7:3], bit 15 = 1 only if alpha is exactly 0x40, and bits [31:16]=0. With fmt16_i low, the 32-bit pixel is output as is.
- R7: out_last_o is high on every MB_DIM*MB_DIM-th pixel accepted since reset, and low on all others.
- R8: An accepted pixel appears on the output one cycle later. in_ready_o is high whenever the output register is empty or being drained. A stalled output holds out_valid_o and its data stable.
- R9: During and right after reset, out_valid_o is low and in_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_we_i | input | 1 | Threshold command strobe |
| cmd_i | input | 32 | Threshold command word |
| in_valid_i | input | 1 | Input pixel valid |
| in_ready_o | output | 1 | Input pixel ready |
| in_pix_i | input | 32 | Input RGB32 pixel |
| sign_i | input | 1 | Flip colour sign bits for this pixel |
| fmt16_i | input | 1 | 1 selects RGB16 output, 0 selects RGB32 |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Output pixel ready |
| out_pix_o | output | 32 | Output pixel (RGB16 uses bits [15:0]) |
| out_last_o | output | 1 | Last pixel of a macroblock |

## Verification
The bench builds the block with MB_DIM set to 4, so a macroblock is 16 pixels long. This lets the last flag be checked over two full macroblocks, and checked again after a mid-stream reset, in a few dozen cycles. The threshold, sign and packing rules do not depend on MB_DIM. They are exercised at their boundaries: channels equal to a level, the low level set above the high level, and an alpha one code away from 0x40.

// File: rtl/rgb_key_pkg.sv
package rgb_key_pkg;
  localparam int CH_W    = 8;
  localparam int N_CH    = 3;
  localparam int PIX_W   = 4 * CH_W;
  localparam int PK_CH_W = 5;
  localparam logic [CH_W-1:0] HALF_ALPHA = 8'h40;
  localparam int T0_LSB  = 0;
  localparam int T1_LSB  = 16;
endpackage

// File: rtl/rgb_key_thresh_regs.sv
module rgb_key_thresh_regs
  import rgb_key_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  logic [31:0]      cmd_i,
  output logic [CH_W-1:0]  lvl_lo_o,
  output logic [CH_W-1:0]  lvl_hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_lo_o <= '0;
      lvl_hi_o <= '0;
    end else if (cmd_we_i) begin
      lvl_lo_o <= cmd_i[T0_LSB +: CH_W];
      lvl_hi_o <= cmd_i[T1_LSB +: CH_W];
    end
  end
endmodule

// File: rtl/rgb_key_alpha.sv
module rgb_key_alpha
  import rgb_key_pkg::*;
(
  input  logic [PIX_W-1:0] pix_i,
  input  logic [CH_W-1:0]  lvl_lo_i,
  input  logic [CH_W-1:0]  lvl_hi_i,
  input  logic             sign_i,
  output logic [PIX_W-1:0] pix_o
);
  logic [N_CH-1:0]  dark_lo, dark_hi;
  logic [PIX_W-1:0] sign_mask;
  logic [PIX_W-1:0] keyed;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign dark_lo[c] = pix_i[c*CH_W +: CH_W] < lvl_lo_i;
    assign dark_hi[c] = pix_i[c*CH_W +: CH_W] < lvl_hi_i;
    assign sign_mask[c*CH_W +: CH_W] = {sign_i, {(CH_W-1){1'b0}}};
  end
  assign sign_mask[N_CH*CH_W +: CH_W] = '0;

  always_comb begin
    if (&dark_lo)      keyed = '0;
    else if (&dark_hi) keyed = {HALF_ALPHA, pix_i[N_CH*CH_W-1:0]};
    else               keyed = pix_i;
    pix_o = keyed ^ sign_mask;
  end
endmodule

// File: rtl/rgb_key_pack.sv
module rgb_key_pack
  import rgb_key_pkg::*;
(
  input  logic [PIX_W-1:0] pix_i,
  input  logic             fmt16_i,
  output logic [PIX_W-1:0] pix_o
);
  localparam int PK_W = N_CH * PK_CH_W + 1;
  logic [PK_W-1:0] packed16;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign packed16[c*PK_CH_W +: PK_CH_W] = pix_i[c*CH_W + CH_W - PK_CH_W +: PK_CH_W];
  end
  assign packed16[PK_W-1] = pix_i[N_CH*CH_W +: CH_W] == HALF_ALPHA;

  assign pix_o = fmt16_i ? {{(PIX_W-PK_W){1'b0}}, packed16} : pix_i;
endmodule

// File: rtl/rgb_key_mb_counter.sv
module rgb_key_mb_counter #(
  parameter int MB_PIX = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic last_o
);
  localparam int CNT_W = (MB_PIX > 1) ? $clog2(MB_PIX) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MB_PIX - 1);

  logic [CNT_W-1:0] cnt_q;

  assign last_o = cnt_q == CNT_MAX;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rgb_key_packer.sv
module rgb_key_packer
  import rgb_key_pkg::*;
#(
  parameter int MB_DIM = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_we_i,
  input  logic [31:0] cmd_i,
  input  logic        in_valid_i,
  output logic        in_ready_o,
  input  logic [31:0] in_pix_i,
  input  logic        sign_i,
  input  logic        fmt16_i,
  output logic        out_valid_o,
  input  logic        out_ready_i,
  output logic [31:0] out_pix_o,
  output logic        out_last_o
);
  localparam int MB_PIX = MB_DIM * MB_DIM;

  logic [CH_W-1:0]  lvl_lo, lvl_hi;
  logic [PIX_W-1:0] keyed_pix, packed_pix;
  logic             mb_last;
  logic             take;

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign take       = in_valid_i && in_ready_o;

  rgb_key_thresh_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_we_i (cmd_we_i),
    .cmd_i    (cmd_i),
    .lvl_lo_o (lvl_lo),
    .lvl_hi_o (lvl_hi)
  );

  rgb_key_alpha u_alpha (
    .pix_i    (in_pix_i),
    .lvl_lo_i (lvl_lo),
    .lvl_hi_i (lvl_hi),
    .sign_i   (sign_i),
    .pix_o    (keyed_pix)
  );

  rgb_key_pack u_pack (
    .pix_i   (keyed_pix),
    .fmt16_i (fmt16_i),
    .pix_o   (packed_pix)
  );

  rgb_key_mb_counter #(.MB_PIX(MB_PIX)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (take),
    .last_o (mb_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_pix_o   <= '0;
      out_last_o  <= 1'b0;
    end else if (take) begin
      out_valid_o <= 1'b1;
      out_pix_o   <= packed_pix;
      out_last_o  <= mb_last;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rgb_key_packer_chk.sv
module rgb_key_packer_chk #(
  parameter int MB_DIM = 16
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic        in_ready_o,
  input logic        fmt16_i,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [31:0] out_pix_o,
  input logic        out_last_o
);
  localparam int MB_PIX = MB_DIM * MB_DIM;
  localparam int CW = (MB_PIX > 1) ? $clog2(MB_PIX) : 1;
  localparam logic [CW-1:0] CMAX = CW'(MB_PIX - 1);

  logic [CW-1:0] seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= '0;
    else if (out_valid_o && out_ready_i) seen_q <= (seen_q == CMAX) ? '0 : seen_q + 1'b1;
  end

  assert_last_pos_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_last_o == (seen_q == CMAX)));

  assert_stall_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_pix_o) && $stable(out_last_o)));

  assert_one_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o);

  assert_empty_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);

  assert_pack_upper_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && fmt16_i) |=> (out_pix_o[31:16] == 16'h0));
endmodule

bind rgb_key_packer rgb_key_packer_chk #(.MB_DIM(MB_DIM)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .fmt16_i     (fmt16_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_pix_o   (out_pix_o),
  .out_last_o  (out_last_o)
);

// File: tb/rgb_key_packer_test.sv
module rgb_key_packer_test;
  localparam int MB_DIM = 4;
  localparam int MB_PIX = MB_DIM * MB_DIM;
  localparam int NV = 13;
  // {cmd, sign, fmt16, pixel, expected}
  localparam logic [97:0] VEC [NV] = '{
    {32'h0000_0000, 1'b0, 1'b0, 32'h1234_5678, 32'h1234_5678}, // R4
    {32'h0000_0000, 1'b1, 1'b0, 32'h1234_5678, 32'h12B4_D6F8}, // R5
    {32'h0020_0010, 1'b0, 1'b0, 32'hFF0F_0F0F, 32'h0000_0000}, // R2
    {32'h0020_0010, 1'b0, 1'b0, 32'hFF0F_0F10, 32'h400F_0F10}, // R3 R at lo edge
    {32'h0020_0010, 1'b0, 1'b0, 32'hFF0F_2010, 32'hFF0F_2010}, // R3 G at hi edge
    {32'h0020_0000, 1'b0, 1'b0, 32'h770A_0B0C, 32'h400A_0B0C}, // R3 lo zero
    {32'h0008_0040, 1'b0, 1'b0, 32'h9905_0505, 32'h0000_0000}, // R2 priority
    {32'h0008_0040, 1'b1, 1'b0, 32'h9905_0505, 32'h0080_8080}, // R5 after erase
    {32'h0000_0000, 1'b0, 1'b1, 32'h40F8_7C1F, 32'h0000_FDE3}, // R6
    {32'h0000_0000, 1'b0, 1'b1, 32'h41FF_FFFF, 32'h0000_7FFF}, // R6 alpha 0x41
    {32'h0020_0000, 1'b0, 1'b1, 32'h0010_1010, 32'h0000_8842}, // R6 with R3
    {32'hAB00_CD00, 1'b0, 1'b0, 32'h0001_0101, 32'h0001_0101}, // R1 ignored bits
    {32'h0000_0000, 1'b1, 1'b1, 32'h0000_0000, 32'h0000_4210}  // R5 R6
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_pix = '0;
  logic        sign = 1'b0;
  logic        fmt16 = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_pix;
  logic        out_last;

  int checks = 0;
  int errors = 0;
  int sent = 0;

  always #4 clk = ~clk;

  rgb_key_packer #(.MB_DIM(MB_DIM)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_i(cmd),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_pix_i(in_pix),
    .sign_i(sign), .fmt16_i(fmt16), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_pix_o(out_pix), .out_last_o(out_last)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load_cmd(input logic [31:0] c);
    @(negedge clk);
    cmd_we = 1'b1; cmd = c;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic send(input logic [31:0] p, input logic s, input logic f,
                      input logic [31:0] exp, input string req);
    @(negedge clk);
    in_pix = p; sign = s; fmt16 = f; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    sent++;
    check({req, " valid"}, {31'b0, out_valid}, 32'd1);
    check(req, out_pix, exp);
    check("R7 last", {31'b0, out_last}, {31'b0, (sent % MB_PIX) == 0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 out_valid in reset", {31'b0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 out_valid", {31'b0, out_valid}, 32'd0);
    check("R9 in_ready", {31'b0, in_ready}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      load_cmd(VEC[i][97:66]);
      send(VEC[i][63:32], VEC[i][65], VEC[i][64], VEC[i][31:0], $sformatf("R1-vec%0d", i));
    end

    // R1: new levels not applied to a pixel accepted in the command cycle
    load_cmd(32'h0);
    @(negedge clk);
    cmd_we = 1'b1; cmd = 32'h0000_00FF;
    in_pix = 32'h1101_0101; sign = 1'b0; fmt16 = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0; in_valid = 1'b0; sent++;
    check("R1 same-cycle", out_pix, 32'h1101_0101);
    check("R7 last", {31'b0, out_last}, {31'b0, (sent % MB_PIX) == 0});
    send(32'h1101_0101, 1'b0, 1'b0, 32'h0, "R1 next-cycle R2");

    // R8: stall holds output
    @(negedge clk);
    out_ready = 1'b0;
    in_pix = 32'h2233_4455; sign = 1'b0; fmt16 = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    sent++;
    check("R8 in_ready low on stall", {31'b0, in_ready}, 32'd0);
    in_pix = 32'hDEAD_BEEF;
    repeat (2) @(negedge clk);
    check("R8 held valid", {31'b0, out_valid}, 32'd1);
    check("R8 held data", out_pix, 32'h0);
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    check("R8 drained", {31'b0, out_valid}, 32'd0);

    // R7: finish through two full macroblocks
    while (sent < 2 * MB_PIX) send(32'h0000_0000, 1'b0, 1'b0, 32'h0, "R7 stream");

    // R9 R1 R7: reset mid-stream clears levels and count
    send(32'h0000_0000, 1'b0, 1'b0, 32'h0, "R7 stream");
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 out_valid after reset", {31'b0, out_valid}, 32'd0);
    rst_n = 1'b1;
    sent = 0;
    send(32'h0505_0505, 1'b0, 1'b0, 32'h0505_0505, "R1 levels cleared");
    while (sent < MB_PIX) send(32'h0A0B_0C0D, 1'b0, 1'b0, 32'h0A0B_0C0D, "R7 after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule